// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block holds five compare channels that watch one external 16-bit free-running count. Each channel keeps its own 16-bit compare value. When the count equals that value, the channel raises a flag and can request an interrupt. It can also change one of five output pins. Channels 2 to 5 each steer their own pin with a 2-bit action: hold, toggle, drive low or drive high. Channel 1 is a master channel. On its match it loads a preset level onto any chosen subset of the five pins. Together with a second channel acting on the same pin, this gives edges at two independent times.

A force register lets software fire pin actions at once. A forced action changes the pin only and never sets a flag. The pin of channel 1 is shared with an input, so the master drives it only while a direction bit selects output.

Registers are written through a select code on `wr_sel`. Codes 0 to 4 load the compare value of channels 1 to 5 from `wr_data`. Code 5 clears flags, 6 sets interrupt enables and 7 sets the action fields. Code 8 sets the master pin mask, 9 the master pin data, 10 is the force strobe and 11 the direction register. Codes 12 to 15 are ignored. Every byte-wide register uses `wr_data[7:0]`, and channel bits sit at 7:3 with channel 1 at bit 7. On the `pin_o`, `flag_o` and mask vectors, bit 4 is channel 1 and bit 0 is channel 5.

Top module: `occ_unit`

## Requirements
- R1: When `count_in` equals a channel's compare value at a clock edge, that channel's flag reads 1 after the edge. The flag bit is `flag_o[4]` for channel 1 down to `flag_o[0]` for channel 5. A compare value written at an edge is used from the next edge on.
- R2: Writing select 5 clears each flag whose data bit (7:3) is 1. If the same flag also matches in that cycle, the match wins and the flag stays set.
- R3: `irq` is 1 exactly when some flag is set whose enable bit is set. The enables are written with select 6, at data bits 7:3 in flag order.
- R4: For channels 2 to 5, the action field (select 7) is bits 7:6 for channel 2, 5:4 for channel 3, 3:2 for channel 4 and 1:0 for channel 5. On a match, 00 leaves the pin alone, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R5: On a channel 1 match, each pin whose master mask bit (select 8, bits 7:3) is 1 takes the matching master data bit (select 9, bits 7:3).
- R6: When the master and a channel's own action change the same pin at the same edge, the master's level is the result.
- R7: Writing select 10 with bit 7 to 3 set performs that channel's pin action at the edge that takes the write: the own action for channels 2 to 5, the master load for channel 1. No flag is set.
- R8: The master changes pin 1 (`pin_o[4]`) only while direction bit 7 (select 11) is 1. `pin1_oe` shows that bit.
- R9: After reset all compare values are FFFF. Pins, flags, enables, actions, master mask and data and direction are all 0.
- R10: Select codes 12 to 15 change no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_in | input | 16 | Shared free-running count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select code |
| wr_data | input | 16 | Write data |
| pin_o | output | 5 | Compare pin levels, bit 4 is channel 1 |
| pin1_oe | output | 1 | Output enable of the channel 1 pin |
| flag_o | output | 5 | Compare flags, bit 4 is channel 1 |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle here. A master load can meet an own pin action on one pin, and a flag clear can meet a new match on that flag. The bench sets channel 1 and channel 2 to one compare value and points the master mask at pin 2. It then checks after the edge that the pin shows the master data and not the own action. It also writes a flag clear in the very cycle the count matches that channel, and expects the flag still set. Random writes over a narrow count range make these collisions happen often, and every output is judged against a bench model built from the requirements.

// File: rtl/occ_unit.sv
module occ_unit #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_in,
  input  logic          wr_en,
  input  logic [3:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [4:0]    pin_o,
  output logic          pin1_oe,
  output logic [4:0]    flag_o,
  output logic          irq
);
  localparam logic [3:0] SEL_CLR = 4'd5, SEL_IEN = 4'd6, SEL_ACT = 4'd7,
                         SEL_MMSK = 4'd8, SEL_MDAT = 4'd9, SEL_FRC = 4'd10,
                         SEL_DIR = 4'd11;

  logic [CW-1:0] cmp_q [5];
  logic [4:0] flag_q, ien_q, mmsk_q, mdat_q, pin_q, pin_d, match, frc, trig, clr;
  logic [7:0] act_q;
  logic       dir_q;

  always_comb
    for (int b = 0; b < 5; b++) match[b] = (count_in == cmp_q[b]);

  assign frc  = (wr_en && wr_sel == SEL_FRC) ? wr_data[7:3] : 5'd0;
  assign clr  = (wr_en && wr_sel == SEL_CLR) ? wr_data[7:3] : 5'd0;
  assign trig = match | frc;

  always_comb begin
    pin_d = pin_q;
    for (int b = 0; b < 4; b++)
      if (trig[b])
        case (act_q[2*b +: 2])
          2'b01: pin_d[b] = ~pin_q[b];
          2'b10: pin_d[b] = 1'b0;
          2'b11: pin_d[b] = 1'b1;
          default: ;
        endcase
    if (trig[4])
      for (int b = 0; b < 5; b++)
        if (mmsk_q[b] && (b != 4 || dir_q)) pin_d[b] = mdat_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 5; b++) cmp_q[b] <= '1;
      flag_q <= '0;
      ien_q  <= '0;
      mmsk_q <= '0;
      mdat_q <= '0;
      act_q  <= '0;
      dir_q  <= 1'b0;
      pin_q  <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | match;
      pin_q  <= pin_d;
      if (wr_en) begin
        if (wr_sel < 4'd5) cmp_q[4 - wr_sel] <= wr_data;
        case (wr_sel)
          SEL_IEN:  ien_q  <= wr_data[7:3];
          SEL_ACT:  act_q  <= wr_data[7:0];
          SEL_MMSK: mmsk_q <= wr_data[7:3];
          SEL_MDAT: mdat_q <= wr_data[7:3];
          SEL_DIR:  dir_q  <= wr_data[7];
          default: ;
        endcase
      end
    end
  end

  assign pin_o   = pin_q;
  assign flag_o  = flag_q;
  assign pin1_oe = dir_q;
  assign irq     = |(flag_q & ien_q);

  AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    |match |=> ((flag_q & $past(match)) == $past(match))); // R1
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q != 5'd0)); // R3
  AST_MASTER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (match[4] && mmsk_q[3]) |=> (pin_q[3] == $past(mdat_q[3]))); // R6
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((frc != 5'd0) && (match == 5'd0) && (flag_q == 5'd0)) |=> (flag_q == 5'd0)); // R7
  AST_PIN1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_q |=> (pin_q[4] == $past(pin_q[4]))); // R8
endmodule

// File: tb/sim_occ_unit.sv
module sim_occ_unit;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] count_in = '0, wr_data = '0;
  logic [3:0] wr_sel = '0;
  logic [4:0] pin_o, flag_o;
  logic pin1_oe, irq;
  int vecs = 0, errs = 0;
  bit done = 0;

  logic [15:0] mcmp [5];
  logic [4:0] mflag, mien, mmm, mmd, mpin;
  logic [7:0] mact;
  logic mdir;

  occ_unit u0 (.clk(clk), .rst_n(rst_n), .count_in(count_in), .wr_en(wr_en),
               .wr_sel(wr_sel), .wr_data(wr_data), .pin_o(pin_o), .pin1_oe(pin1_oe),
               .flag_o(flag_o), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input string tag);
    chk({tag, " pins"}, {11'd0, pin_o}, {11'd0, mpin});
    chk({tag, " flags"}, {11'd0, flag_o}, {11'd0, mflag});
    chk({tag, " irq R3"}, {15'd0, irq}, {15'd0, |(mflag & mien)});
    chk({tag, " oe R8"}, {15'd0, pin1_oe}, {15'd0, mdir});
  endtask

  task automatic model_reset();
    for (int b = 0; b < 5; b++) mcmp[b] = 16'hFFFF;
    mflag = 0; mien = 0; mmm = 0; mmd = 0; mpin = 0; mact = 0; mdir = 0;
  endtask

  task automatic step(input bit we, input logic [3:0] s, input logic [15:0] d,
                      input logic [15:0] cnt, input string tag);
    logic [4:0] m, t, f, c, np;
    @(negedge clk);
    wr_en = we; wr_sel = s; wr_data = d; count_in = cnt;
    for (int b = 0; b < 5; b++) m[b] = (cnt == mcmp[b]);
    f = (we && s == 4'd10) ? d[7:3] : 5'd0;
    c = (we && s == 4'd5) ? d[7:3] : 5'd0;
    t = m | f;
    np = mpin;
    for (int b = 0; b < 4; b++)
      if (t[b]) begin
        if (mact[2*b +: 2] == 2'b01) np[b] = ~mpin[b];
        else if (mact[2*b +: 2] == 2'b10) np[b] = 1'b0;
        else if (mact[2*b +: 2] == 2'b11) np[b] = 1'b1;
      end
    if (t[4])
      for (int b = 0; b < 5; b++)
        if (mmm[b] && (b != 4 || mdir)) np[b] = mmd[b];
    @(posedge clk);
    mflag = (mflag & ~c) | m;
    mpin = np;
    if (we) begin
      if (s < 4'd5) mcmp[4 - s] = d;
      else if (s == 4'd6) mien = d[7:3];
      else if (s == 4'd7) mact = d[7:0];
      else if (s == 4'd8) mmm = d[7:3];
      else if (s == 4'd9) mmd = d[7:3];
      else if (s == 4'd11) mdir = d[7];
    end
    #1;
    cmp_all(tag);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    cmp_all("R9 reset");
    rst_n = 1'b1;
    step(0, 0, 0, 16'hFFFF, "R9 compare FFFF");
    step(1, 4'd5, 16'h00F8, 16'h0001, "R2 clear all");
    step(1, 4'd2, 16'h0010, 16'h0010, "R1 write ch3 no early match");
    step(0, 0, 0, 16'h0010, "R1 ch3 match");
    step(1, 4'd5, 16'h0020, 16'h0010, "R2 set beats clear");
    step(1, 4'd5, 16'h0020, 16'h0000, "R2 clear");
    step(1, 4'd6, 16'h0020, 16'h0010, "R3 enable and match");
    step(1, 4'd7, 16'h0010, 16'h0000, "R4 ch3 toggle");
    step(0, 0, 0, 16'h0010, "R4 toggle up");
    step(0, 0, 0, 16'h0010, "R4 toggle down");
    step(1, 4'd0, 16'h0020, 16'h0000, "R5 cmp1");
    step(1, 4'd1, 16'h0020, 16'h0000, "R6 cmp2");
    step(1, 4'd7, 16'h00C0, 16'h0000, "R6 ch2 drive high");
    step(1, 4'd8, 16'h00C8, 16'h0000, "R5 mask");
    step(1, 4'd9, 16'h0088, 16'h0000, "R5 data");
    step(0, 0, 0, 16'h0020, "R6 master beats own, R8 pin1 held");
    step(1, 4'd11, 16'h0080, 16'h0000, "R8 dir on");
    step(0, 0, 0, 16'h0020, "R5 master load with pin1");
    step(1, 4'd5, 16'h00F8, 16'h0000, "R2 clear");
    step(1, 4'd7, 16'h000C, 16'h0000, "R7 ch4 high");
    step(1, 4'd10, 16'h0010, 16'h0000, "R7 force ch4 no flag");
    step(1, 4'd9, 16'h0000, 16'h0000, "R7 data zero");
    step(1, 4'd10, 16'h0080, 16'h0000, "R7 force master");
    for (int s = 12; s < 16; s++)
      step(1, s[3:0], 16'hFFFF, 16'h0000, "R10 unused select");
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] s;
      logic [15:0] d;
      s = 4'($urandom_range(0, 15));
      d = 16'($urandom);
      if (s < 4'd5) d = {11'd0, d[4:0]};
      step($urandom_range(0, 2) != 0, s, d, 16'($urandom_range(0, 31)), "R1 R4 R5 random");
    end
    rst_n = 1'b0;
    #1;
    model_reset();
    #20;
    cmp_all("R9 second reset");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule